// File: doc/BRIEF.md
# Receive Gain Adapt-and-Lock Sequencer

This block decides in every clock cycle whether the receive gain loop may move its gain and offset codes or must hold them. A level detector outside the block sends single-step requests (raise or lower, aimed at either the gain code or the offset code). The sequencer lets a request through only while adaptation is allowed, and it keeps both codes inside their legal ranges.

Adaptation runs freely while the PHY's carrier-select line is low. When the PHY detects a preamble and raises carrier-select, adaptation goes on for a fixed settling window so the loop can finish converging. After that the codes in place are locked. They stay locked while carrier-select stays high, and the fall of carrier-select releases them. A freeze input holds the codes at any time. A manual mode drives the outputs from configuration codes instead of the accumulated ones and leaves the accumulated codes untouched. The 7-bit gain code spans a range of about 54 dB.

Top module: `agc_lock_seq`

## Requirements
- R1: During reset the sequencer is cleared. With reset released, carrier-select low, freeze low and manual mode off, `gain_o` reads 127 (the maximum code), `offset_o` reads 32 and `adapt_en_o` is 1.
- R2: A step request is applied at the next clock edge when `adapt_en_o` is 1 and `step_valid_i` is 1. `step_sel_i`=0 targets the gain code and 1 targets the offset code. `step_up_i`=1 adds one and 0 subtracts one.
- R3: Say carrier-select is first sampled high in cycle k after an adapting period. Then `adapt_en_o` stays 1 in cycle k and in the SETTLE_CYC cycles that follow, and it is 0 from cycle k+SETTLE_CYC+1 onward while carrier-select stays high.
- R4: Once locked, and while carrier-select stays high, `adapt_en_o` is 0 and step requests leave `gain_o` and `offset_o` unchanged.
- R5: If carrier-select falls before the settling window ends, the window is cancelled and adaptation continues. The next rise starts a full new window.
- R6: If carrier-select falls while locked, `adapt_en_o` returns to 1 in the following cycle.
- R7: While `freeze_i` is 1, `adapt_en_o` is 0 and step requests change no code. The settling window still runs while freeze is high.
- R8: While `manual_en_i` is 1, `gain_o` equals `manual_gain_i`, `offset_o` equals `manual_offset_i` and `adapt_en_o` is 0. When manual mode ends, the accumulated codes reappear unchanged.
- R9: Steps saturate. The gain code stays within 0..127 and the offset code within 0..63, so a step past either end leaves the code where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_i | input | 1 | Carrier-select from the PHY, raised on preamble detection |
| freeze_i | input | 1 | Holds both codes while high |
| manual_en_i | input | 1 | Manual mode: outputs come from the configuration codes |
| manual_gain_i | input | 7 | Configured gain code for manual mode |
| manual_offset_i | input | 6 | Configured offset code for manual mode |
| step_valid_i | input | 1 | Step request from the level detector |
| step_sel_i | input | 1 | Request target: 0 gain, 1 offset |
| step_up_i | input | 1 | Request direction: 1 up, 0 down |
| adapt_en_o | output | 1 | Adaptation allowed this cycle |
| gain_o | output | 7 | Applied gain code |
| offset_o | output | 6 | Applied offset code |

## Verification
The bench builds the block with SETTLE_CYC set to 5 instead of 32. This keeps windows short, so one run can cover a full window followed by a lock, a window cancelled part-way and restarted, and freeze asserted in the middle of a window. The code widths stay at 7 and 6 bits. That keeps the real saturation points at 127, 0 and 63, which a run of 130 downward steps reaches.

// File: rtl/agc_lock_pkg.sv
package agc_lock_pkg;

    localparam int unsigned GAIN_W_DEF   = 7;
    localparam int unsigned OFF_W_DEF    = 6;
    localparam int unsigned SETTLE_DEF   = 32;

    typedef enum logic [1:0] {
        ST_ADAPT  = 2'd0,
        ST_SETTLE = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic valid;
        logic sel;   // 0 gain, 1 offset
        logic up;
    } step_req_t;

    // one-code move clamped to [0, vmax]
    function automatic int unsigned sat_step(int unsigned v, logic up, int unsigned vmax);
        if (up)
            return (v >= vmax) ? vmax : v + 1;
        else
            return (v == 0) ? 0 : v - 1;
    endfunction

endpackage

// File: rtl/agc_lock_fsm.sv
module agc_lock_fsm
    import agc_lock_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = SETTLE_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        carrier_i,
    output lock_state_e state_o,
    output logic        allow_o
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);

    lock_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ADAPT;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_ADAPT: begin
                    if (carrier_i) begin
                        state_q <= ST_SETTLE;
                        cnt_q   <= CNT_W'(SETTLE_CYC - 1);
                    end
                end
                ST_SETTLE: begin
                    if (!carrier_i)
                        state_q <= ST_ADAPT;
                    else if (cnt_q == '0)
                        state_q <= ST_LOCKED;
                    else
                        cnt_q <= cnt_q - 1'b1;
                end
                ST_LOCKED: begin
                    if (!carrier_i)
                        state_q <= ST_ADAPT;
                end
                default: state_q <= ST_ADAPT;
            endcase
        end
    end

    assign state_o = state_q;
    assign allow_o = (state_q != ST_LOCKED);

    // R4: lock persists while carrier-select stays high
    p_lock_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCKED && carrier_i) |=> (state_q == ST_LOCKED));
    // R5 / R6: a low carrier-select always leads back to adapting
    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        !carrier_i |=> (state_q == ST_ADAPT));
    // R3: the window cannot end early while the count is nonzero
    p_settle_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETTLE && carrier_i && cnt_q != '0) |=> (state_q == ST_SETTLE));

endmodule

// File: rtl/agc_code_acc.sv
module agc_code_acc
    import agc_lock_pkg::*;
#(
    parameter int unsigned W         = GAIN_W_DEF,
    parameter int unsigned RESET_VAL = (1 << GAIN_W_DEF) - 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en_i,
    input  logic         step_up_i,
    output logic [W-1:0] code_o
);
    localparam int unsigned CODE_MAX = (1 << W) - 1;

    logic [W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= W'(RESET_VAL);
        else if (step_en_i)
            code_q <= W'(sat_step(int'(code_q), step_up_i, CODE_MAX));
    end

    assign code_o = code_q;

    // R7 / R4: no enable, no movement
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !step_en_i |=> $stable(code_q));
    // R9: saturation at the top
    p_sat_top_r9: assert property (@(posedge clk) disable iff (rst)
        (step_en_i && step_up_i && code_q == W'(CODE_MAX)) |=> (code_q == W'(CODE_MAX)));
    // R9: saturation at the bottom
    p_sat_bot_r9: assert property (@(posedge clk) disable iff (rst)
        (step_en_i && !step_up_i && code_q == '0) |=> (code_q == '0));

endmodule

// File: rtl/agc_lock_seq.sv
module agc_lock_seq
    import agc_lock_pkg::*;
#(
    parameter int unsigned GAIN_W     = GAIN_W_DEF,
    parameter int unsigned OFF_W      = OFF_W_DEF,
    parameter int unsigned SETTLE_CYC = SETTLE_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              carrier_i,
    input  logic              freeze_i,
    input  logic              manual_en_i,
    input  logic [GAIN_W-1:0] manual_gain_i,
    input  logic [OFF_W-1:0]  manual_offset_i,
    input  logic              step_valid_i,
    input  logic              step_sel_i,
    input  logic              step_up_i,
    output logic              adapt_en_o,
    output logic [GAIN_W-1:0] gain_o,
    output logic [OFF_W-1:0]  offset_o
);
    localparam int unsigned GAIN_RST = (1 << GAIN_W) - 1;
    localparam int unsigned OFF_RST  = 1 << (OFF_W - 1);

    lock_state_e       state;
    logic              fsm_allow;
    logic              adapt;
    step_req_t         req;
    logic [GAIN_W-1:0] acc_gain;
    logic [OFF_W-1:0]  acc_off;

    assign req = '{valid: step_valid_i, sel: step_sel_i, up: step_up_i};

    agc_lock_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .carrier_i (carrier_i),
        .state_o   (state),
        .allow_o   (fsm_allow)
    );

    assign adapt = fsm_allow && !freeze_i && !manual_en_i;

    agc_code_acc #(.W(GAIN_W), .RESET_VAL(GAIN_RST)) u_gain (
        .clk       (clk),
        .rst       (rst),
        .step_en_i (adapt && req.valid && !req.sel),
        .step_up_i (req.up),
        .code_o    (acc_gain)
    );

    agc_code_acc #(.W(OFF_W), .RESET_VAL(OFF_RST)) u_off (
        .clk       (clk),
        .rst       (rst),
        .step_en_i (adapt && req.valid && req.sel),
        .step_up_i (req.up),
        .code_o    (acc_off)
    );

    assign adapt_en_o = adapt;
    assign gain_o     = manual_en_i ? manual_gain_i   : acc_gain;
    assign offset_o   = manual_en_i ? manual_offset_i : acc_off;

    // R7: freeze always wins
    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        freeze_i |-> !adapt_en_o);
    // R4: a locked loop never adapts
    p_locked_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCKED) |-> !adapt_en_o);
    // R8: manual mode leaves the accumulated codes alone
    p_manual_r8: assert property (@(posedge clk) disable iff (rst)
        manual_en_i |=> ($stable(acc_gain) && $stable(acc_off)));

endmodule

// File: tb/agc_lock_seq_bench.sv
module agc_lock_seq_bench;
    localparam int unsigned N = 5;

    logic       clk = 0;
    logic       rst, carrier, freeze, manual, sv, ssel, sup;
    logic [6:0] mgain;
    logic [5:0] moff;
    logic       adapt_en;
    logic [6:0] gain;
    logic [5:0] offset;

    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct {
        logic       adapt;
        logic [6:0] gain;
        logic [5:0] off;
        string      tag;
    } exp_t;
    exp_t q[$];

    // bench model state, built from the requirements
    int m_st = 0, m_cnt = 0, m_gain = 127, m_off = 32;

    always #5 clk = ~clk;

    agc_lock_seq #(.GAIN_W(7), .OFF_W(6), .SETTLE_CYC(N)) u_agc_lock_seq (
        .clk(clk), .rst(rst), .carrier_i(carrier), .freeze_i(freeze),
        .manual_en_i(manual), .manual_gain_i(mgain), .manual_offset_i(moff),
        .step_valid_i(sv), .step_sel_i(ssel), .step_up_i(sup),
        .adapt_en_o(adapt_en), .gain_o(gain), .offset_o(offset)
    );

    task automatic apply(input logic r, input logic c, input logic f, input logic m,
                         input logic [6:0] mg, input logic [5:0] mo,
                         input logic v, input logic s, input logic u, input string tag);
        logic a;
        @(negedge clk);
        rst = r; carrier = c; freeze = f; manual = m; mgain = mg; moff = mo;
        sv = v; ssel = s; sup = u;
        #1;
        a = (m_st != 2) && !f && !m;
        if (!r) q.push_back('{a, m ? mg : 7'(m_gain), m ? mo : 6'(m_off), tag});
        if (r) begin
            m_st = 0; m_cnt = 0; m_gain = 127; m_off = 32;
        end else begin
            if (a && v) begin
                if (!s) m_gain = u ? ((m_gain >= 127) ? 127 : m_gain + 1) : ((m_gain == 0) ? 0 : m_gain - 1);
                else    m_off  = u ? ((m_off  >= 63)  ? 63  : m_off + 1)  : ((m_off  == 0) ? 0 : m_off - 1);
            end
            case (m_st)
                0: if (c) begin m_st = 1; m_cnt = N - 1; end
                1: if (!c) m_st = 0; else if (m_cnt == 0) m_st = 2; else m_cnt--;
                default: if (!c) m_st = 0;
            endcase
        end
    endtask

    // shorthand: normal cycle with no manual codes
    task automatic cyc(input logic c, input logic f, input logic v, input logic s,
                       input logic u, input string tag);
        apply(0, c, f, 0, 7'h00, 6'h00, v, s, u, tag);
    endtask

    // monitor: pop and compare the expected item for this cycle
    always @(negedge clk) begin
        exp_t e;
        #2;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (adapt_en !== e.adapt) begin
                errors++;
                $display("FAIL %s adapt_en actual=%0b expected=%0b", e.tag, adapt_en, e.adapt);
            end
            checks++;
            if (gain !== e.gain) begin
                errors++;
                $display("FAIL %s gain actual=%0d expected=%0d", e.tag, gain, e.gain);
            end
            checks++;
            if (offset !== e.off) begin
                errors++;
                $display("FAIL %s offset actual=%0d expected=%0d", e.tag, offset, e.off);
            end
        end
    end

    initial begin
        #(200_000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; carrier = 0; freeze = 0; manual = 0; mgain = 0; moff = 0;
        sv = 0; ssel = 0; sup = 0;
        apply(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        apply(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        // R1: reset values
        cyc(0, 0, 0, 0, 0, "R1");
        // R9: gain already at top, up stays 127
        cyc(0, 0, 1, 0, 1, "R9");
        cyc(0, 0, 1, 0, 1, "R9");
        // R2: gain down, offset up and down
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, "R2");
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, 1, "R2");
        cyc(0, 0, 1, 1, 0, "R2");
        cyc(0, 0, 0, 0, 0, "R2");
        // R9: offset up to 63 and beyond
        for (int i = 0; i < 36; i++) cyc(0, 0, 1, 1, 1, "R9");
        // R9: gain down to 0 and beyond
        for (int i = 0; i < 130; i++) cyc(0, 0, 1, 0, 0, "R9");
        for (int i = 0; i < 20; i++) cyc(0, 0, 1, 0, 1, "R2");
        // R3 / R4: rise, window, lock with steps ignored
        for (int i = 0; i < 10; i++) cyc(1, 0, 1, 0, 1, i < 7 ? "R3" : "R4");
        for (int i = 0; i < 4; i++) cyc(1, 0, 1, 1, 0, "R4");
        // R6: fall releases the lock
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0, "R6");
        // R5: cancel mid-window, then full restart
        for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 1, "R5");
        cyc(0, 0, 1, 0, 1, "R5");
        for (int i = 0; i < 9; i++) cyc(1, 0, 1, 0, 0, "R5");
        cyc(0, 0, 0, 0, 0, "R6");
        // R7: freeze while carrier low, then freeze inside a window
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, 1, "R7");
        cyc(0, 0, 1, 1, 0, "R7");
        for (int i = 0; i < 8; i++) cyc(1, (i >= 1 && i <= 3), 1, 0, 1, "R7");
        cyc(0, 0, 0, 0, 0, "R7");
        // R8: manual codes override; accumulated codes come back
        for (int i = 0; i < 4; i++) apply(0, 0, 0, 1, 7'h55, 6'h2A, 1, i[0], 1, "R8");
        apply(0, 1, 0, 1, 7'h03, 6'h3F, 1, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, "R8");
        cyc(0, 0, 1, 1, 0, "R8");
        cyc(0, 0, 0, 0, 0, "R8");
        // R1: reset again mid-run restores defaults
        apply(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        cyc(0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule